// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the interval between pulses arriving on one fan tachometer input. The pin is brought into the clock domain, passed through a selectable glitch filter, and watched for the edge pattern that software picks. A base-4 exponential prescaler slows the count, and the number of prescaled ticks between two qualifying edges is captured as an unsigned result. If no qualifying edge arrives before the counter tops out, the maximum value is captured as a stalled-fan reading.

Each captured result is compared against a programmable limit. Depending on a direction bit, a result above or below the limit raises an interrupt flag, provided interrupts are enabled. Status outputs show the synchronized pin level, the filtered level, a "new result" flag, and a "result valid" flag. The two sticky flags are cleared by one-cycle clear strobes. Converting the count to speed and register access belong to the surrounding logic.

Top module: `fan_tach_meter`

## Requirements
- R1: While reset is asserted, every output is 0.
- R2: `raw_level` equals `tach_in` delayed by exactly two clocks.
- R3: `deb_level` takes a new level once the synchronized level has differed from it on L+1 consecutive clocks, where L = 3 - `deb_sel` (code 0 gives L = 3, code 3 gives L = 0, so there is no filtering). A shorter pulse leaves `deb_level` unchanged.
- R4: `edge_mode` picks the qualifying edges of `deb_level`: 0 is falling edges only, 1 is rising edges only, and 2 or 3 is every edge.
- R5: A count tick occurs once every 4^n clocks, where n is `div_exp`. Values above `MAX_EXP` (11) behave as 11. The prescaler restarts at every qualifying edge.
- R6: `meas_value` is the number of ticks between two consecutive qualifying edges. It is captured at the second edge. The first qualifying edge after `enable` rises only arms the measurement. `meas_value` changes only on a capture.
- R7: `full_flag` goes to 1 at the first capture after arming and stays at 1 while `enable` is high.
- R8: `upd_flag` goes to 1 on every capture and clears on `upd_clr`. A capture in the same cycle as `upd_clr` wins.
- R9: If the count reaches 2^CNT_W-1 before a qualifying edge, it stops there and that value is captured once as a stalled reading.
- R10: On a capture with `irq_en` high and a non-zero `threshold`, `irq_flag` goes to 1 when the result is greater than `threshold` (`inv_limit` = 0) or less than `threshold` (`inv_limit` = 1).
- R11: `irq_flag` clears on `irq_clr`. A new interrupt in the same cycle as the clear wins.
- R12: While `enable` is low, the counter, the prescaler, the armed state and `full_flag` are cleared. `meas_value` keeps its last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tach_in | input | 1 | Raw tachometer pin |
| enable | input | 1 | Measurement enable |
| deb_sel | input | 2 | Filter length code |
| edge_mode | input | 2 | Qualifying edge pattern |
| div_exp | input | 4 | Prescaler exponent, divide by 4^n |
| threshold | input | CNT_W | Compare limit, 0 turns the compare off |
| inv_limit | input | 1 | 1 = interrupt on a result below the limit |
| irq_en | input | 1 | Interrupt enable |
| upd_clr | input | 1 | Clear strobe for `upd_flag` |
| irq_clr | input | 1 | Clear strobe for `irq_flag` |
| meas_value | output | CNT_W | Last captured tick count |
| upd_flag | output | 1 | New result captured |
| full_flag | output | 1 | A complete interval has been captured |
| raw_level | output | 1 | Synchronized pin level |
| deb_level | output | 1 | Filtered pin level |
| irq_flag | output | 1 | Interrupt status |

## Verification
The bench builds the meter with CNT_W = 8 and keeps MAX_EXP at 11. The narrow counter lets a stalled fan reach the saturation capture within a few hundred clocks, so R9 can be checked next to ordinary periods. Exponents 0 to 2 give exact tick counts on short waveforms. An out-of-range exponent exercises the clamp, and with that setting no tick occurs within the interval.

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
  parameter int CNT_W   = 20,
  parameter int MAX_EXP = 11,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic             enable,
  input  logic [1:0]       deb_sel,
  input  logic [1:0]       edge_mode,
  input  logic [EXP_W-1:0] div_exp,
  input  logic [CNT_W-1:0] threshold,
  input  logic             inv_limit,
  input  logic             irq_en,
  input  logic             upd_clr,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] meas_value,
  output logic             upd_flag,
  output logic             full_flag,
  output logic             raw_level,
  output logic             deb_level,
  output logic             irq_flag
);
  localparam int PRE_W = 2 * MAX_EXP;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic s1, s2, deb, deb_q, armed;
  logic [1:0] stab;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;

  wire [1:0] deb_len = 2'd3 - deb_sel;
  wire [EXP_W-1:0] n_eff = (div_exp > EXP_CAP) ? EXP_CAP : div_exp;
  wire [PRE_W-1:0] pre_top = (PRE_W'(1) << {n_eff, 1'b0}) - PRE_W'(1);
  wire tick = (pre == pre_top);
  wire rise = deb & ~deb_q;
  wire fall = ~deb & deb_q;
  wire qual = (edge_mode == 2'd0) ? fall : (edge_mode == 2'd1) ? rise : (rise | fall);
  wire [CNT_W-1:0] nxt = (cnt == MAXV) ? MAXV : cnt + {{(CNT_W-1){1'b0}}, tick};
  wire stall = (cnt != MAXV) && (nxt == MAXV);
  wire latch = enable && armed && (qual || stall);
  wire hit = (|threshold) && (inv_limit ? (nxt < threshold) : (nxt > threshold));

  assign raw_level = s2;
  assign deb_level = deb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; deb <= 1'b0; deb_q <= 1'b0; stab <= 2'd0;
    end else begin
      s1 <= tach_in;
      s2 <= s1;
      deb_q <= deb;
      if (s2 == deb) stab <= 2'd0;
      else if (stab >= deb_len) begin
        deb  <= s2;
        stab <= 2'd0;
      end else stab <= stab + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= '0; armed <= 1'b0; full_flag <= 1'b0;
      meas_value <= '0; upd_flag <= 1'b0; irq_flag <= 1'b0;
    end else begin
      upd_flag <= latch | (upd_flag & ~upd_clr);
      irq_flag <= (latch & hit & irq_en) | (irq_flag & ~irq_clr);
      if (!enable) begin
        pre <= '0; cnt <= '0; armed <= 1'b0; full_flag <= 1'b0;
      end else begin
        if (latch) begin
          meas_value <= nxt;
          full_flag  <= 1'b1;
        end
        if (qual) begin
          pre <= '0; cnt <= '0; armed <= 1'b1;
        end else if (armed) begin
          pre <= tick ? '0 : pre + PRE_W'(1);
          cnt <= nxt;
        end
      end
    end
  end

  AST_DEB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_level) |-> deb_level == $past(raw_level)); // R3
  AST_VALUE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_value) |-> upd_flag); // R6
  AST_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_flag) |-> upd_flag); // R7
  AST_FULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !full_flag); // R12
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(irq_en) && upd_flag)); // R10
  AST_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_clr && !latch) |=> !upd_flag); // R8
endmodule

// File: tb/tb_fan_tach_meter.sv
module tb_fan_tach_meter;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0, tach_in = 0, enable = 0, inv_limit = 0, irq_en = 0;
  logic upd_clr = 0, irq_clr = 0;
  logic [1:0] deb_sel = 2'd3, edge_mode = 2'd0;
  logic [3:0] div_exp = 4'd0;
  logic [W-1:0] threshold = '0;
  logic [W-1:0] meas_value;
  logic upd_flag, full_flag, raw_level, deb_level, irq_flag;

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  fan_tach_meter #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .enable(enable), .deb_sel(deb_sel),
    .edge_mode(edge_mode), .div_exp(div_exp), .threshold(threshold), .inv_limit(inv_limit),
    .irq_en(irq_en), .upd_clr(upd_clr), .irq_clr(irq_clr), .meas_value(meas_value),
    .upd_flag(upd_flag), .full_flag(full_flag), .raw_level(raw_level),
    .deb_level(deb_level), .irq_flag(irq_flag));

  always #5 clk = ~clk;

  // behavioural reference
  bit m_s1, m_s2, m_deb, m_dq, m_arm, m_full, m_upd, m_irq;
  int m_st, m_cnt, m_val;
  longint m_pre;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_deb = 0; m_dq = 0; m_arm = 0; m_full = 0; m_upd = 0; m_irq = 0;
      m_st = 0; m_cnt = 0; m_val = 0; m_pre = 0;
    end else begin
      bit o_s1, o_s2, o_deb, o_dq, rise, fall, q, tk, lat, hit;
      int len, n, nv;
      longint lim;
      o_s1 = m_s1; o_s2 = m_s2; o_deb = m_deb; o_dq = m_dq;
      len = 3 - int'(deb_sel);
      m_s1 = tach_in; m_s2 = o_s1; m_dq = o_deb;
      if (o_s2 == o_deb) m_st = 0;
      else if (m_st >= len) begin m_deb = o_s2; m_st = 0; end
      else m_st++;
      rise = o_deb && !o_dq; fall = !o_deb && o_dq;
      q = (edge_mode == 0) ? fall : (edge_mode == 1) ? rise : (rise || fall);
      n = (div_exp > 11) ? 11 : int'(div_exp);
      lim = longint'(1) << (2 * n);
      tk = (m_pre == lim - 1);
      nv = (m_cnt == MAXV) ? MAXV : m_cnt + int'(tk);
      lat = enable && m_arm && (q || (m_cnt != MAXV && nv == MAXV));
      hit = (threshold != 0) && (inv_limit ? (nv < int'(threshold)) : (nv > int'(threshold)));
      m_upd = lat || (m_upd && !upd_clr);
      m_irq = (lat && hit && irq_en) || (m_irq && !irq_clr);
      if (!enable) begin m_pre = 0; m_cnt = 0; m_arm = 0; m_full = 0; end
      else begin
        if (lat) begin m_val = nv; m_full = 1; end
        if (q) begin m_pre = 0; m_cnt = 0; m_arm = 1; end
        else if (m_arm) begin m_pre = tk ? 0 : m_pre + 1; m_cnt = nv; end
      end
    end
  end

  task automatic cmp(string r, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] at cycle %0d: actual %0d expected %0d", r, tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    cmp("R6 meas_value", int'(meas_value), m_val);
    cmp("R8 upd_flag", int'(upd_flag), int'(m_upd));
    cmp("R7 full_flag", int'(full_flag), int'(m_full));
    cmp("R2 raw_level", int'(raw_level), int'(m_s2));
    cmp("R3 deb_level", int'(deb_level), int'(m_deb));
    cmp("R10 irq_flag", int'(irq_flag), int'(m_irq));
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(int k); repeat (k) @(negedge clk); endtask
  task automatic wave(int hi, int lo, int reps);
    for (int i = 0; i < reps; i++) begin
      tach_in = 1; step(hi);
      tach_in = 0; step(lo);
    end
  endtask
  task automatic pulse_upd; upd_clr = 1; step(1); upd_clr = 0; endtask
  task automatic pulse_irq; irq_clr = 1; step(1); irq_clr = 0; endtask

  initial begin
    step(3);
    tag = "R1"; cmp("R1 reset value", int'(meas_value), 0);
    cmp("R1 reset flags", int'({upd_flag, full_flag, raw_level, deb_level, irq_flag}), 0);
    rst_n = 1; step(2);
    enable = 1;
    tag = "R4 R6 mode0"; wave(20, 20, 4); step(5);
    cmp("R6 period fall-fall", int'(meas_value), 40);
    cmp("R7 full set", int'(full_flag), 1);
    cmp("R8 upd set", int'(upd_flag), 1);
    tag = "R8 clear"; pulse_upd; cmp("R8 upd cleared", int'(upd_flag), 0);
    tag = "R4 mode1"; edge_mode = 1; wave(15, 25, 4); step(3);
    cmp("R4 rise-rise", int'(meas_value), 40);
    tag = "R4 mode2"; edge_mode = 2; wave(15, 25, 4); step(3);
    cmp("R4 any edge", int'(meas_value), 15);
    tag = "R5 div4"; edge_mode = 0; div_exp = 1; wave(20, 20, 4); step(3);
    cmp("R5 div by 4", int'(meas_value), 10);
    tag = "R5 div16"; div_exp = 2; wave(32, 32, 3); step(3);
    cmp("R5 div by 16", int'(meas_value), 4);
    tag = "R5 clamp"; div_exp = 15; wave(8, 8, 3); step(3);
    cmp("R5 clamped exponent", int'(meas_value), 0);
    tag = "R3 filter"; div_exp = 0; edge_mode = 2; deb_sel = 0; step(10);
    tach_in = 1; step(3); tach_in = 0; step(10);
    cmp("R3 three-cycle glitch filtered", int'(deb_level), 0);
    tach_in = 1; step(10);
    cmp("R3 long pulse accepted", int'(deb_level), 1);
    deb_sel = 1; tach_in = 0; step(2); tach_in = 1; step(10);
    deb_sel = 2; wave(1, 6, 3); wave(2, 6, 3);
    deb_sel = 3; wave(1, 5, 3); step(6);
    tag = "R9 stall"; edge_mode = 0; tach_in = 1; step(10);
    wave(30, 30, 2); tach_in = 0; step(300);
    cmp("R9 saturated reading", int'(meas_value), MAXV);
    tag = "R10 above"; pulse_upd; threshold = 30; irq_en = 1; wave(20, 20, 3); step(3);
    cmp("R10 irq above limit", int'(irq_flag), 1);
    tag = "R11 clear"; pulse_irq; cmp("R11 irq cleared", int'(irq_flag), 0);
    tag = "R10 below"; inv_limit = 1; threshold = 50; wave(20, 20, 2); step(3);
    cmp("R10 irq below limit", int'(irq_flag), 1);
    pulse_irq; tag = "R10 zero"; threshold = 0; wave(20, 20, 3); step(3);
    cmp("R10 zero limit off", int'(irq_flag), 0);
    tag = "R10 gated"; threshold = 30; inv_limit = 0; irq_en = 0; wave(20, 20, 3); step(3);
    cmp("R10 irq gated", int'(irq_flag), 0);
    tag = "R12 disable"; enable = 0; step(3);
    cmp("R12 full cleared", int'(full_flag), 0);
    cmp("R12 value kept", int'(meas_value), 40);
    enable = 1; wave(20, 20, 1); step(3);
    cmp("R12 rearm needs two edges", int'(full_flag), 0);
    wave(20, 20, 2); step(3);
    cmp("R7 full after rearm", int'(full_flag), 1);
    step(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule